// File: doc/BRIEF.md
# Paired-Page Variable-Size Translation Buffer

This block translates a 32-bit virtual address and an 8-bit address space identifier into a 32-bit physical address. It holds 16 tags, and each tag maps two neighbouring virtual pages. Each tag has its own page size, from 4 KB to 16 MB in steps of four. For every entry the lookup works out which virtual bits take part in the compare, which bit picks the even or the odd half, and which low physical bits come straight from the virtual address. It works these out from a 6-bit compressed mask that the entry stores.

A lookup is presented for one cycle on `lk_valid_i`. The result is registered and appears one cycle later. The result gives the hit, the matching index, the physical address, the cacheability code, and the dirty and valid bits of the selected half. It also flags miss, invalid and modified conditions. A separate write port loads one indexed entry in a single cycle from a 12-bit mask image, an entry-high image and two entry-low images. Software must never load two entries that can match the same lookup. If it does, the result is not defined.

Top module: `pair_tlb`

## Requirements
- R1: When `lk_valid_i` is high, the result appears on the outputs one clock later with `res_valid_o` high. Exactly one of `hit_o` and `miss_o` is then set. When `lk_valid_i` is low, `res_valid_o`, `hit_o` and `miss_o` are low in the next cycle. On a hit, `idx_o` gives the matching entry.
- R2: VA[31:25] is always compared with the stored tag. Each VA bit 13+j (j = 0..11) is compared only when bit j of the entry's mask is 0.
- R3: The page-select bit depends on the mask. It is VA[12] for mask 0x000, VA[14] for 0x003, VA[16] for 0x00F, VA[18] for 0x03F, VA[20] for 0x0FF, VA[22] for 0x3FF and VA[24] for 0xFFF. A 0 selects the even half and a 1 selects the odd half.
- R4: `pa_o[11:0]` equals VA[11:0]. For a page of 4^n × 4 KB, PA bits 12 to 11+2n come from the virtual address. The remaining bits come from the upper PFN bits of the selected half.
- R5: The 8-bit ASID must equal the lookup ASID unless the entry is global. The stored global bit is the AND of bit 0 of the two entry-low images.
- R6: On a miss, `miss_o` is high. `idx_o`, `pa_o`, `cattr_o`, `dirty_o`, `pvalid_o`, `inv_o` and `mod_o` are all zero.
- R7: A hit on a half whose valid bit is clear sets `inv_o`, with `pvalid_o` low.
- R8: A store (`lk_store_i` high) that hits a valid half with its dirty bit clear sets `mod_o`. Loads never set `mod_o`. An invalid half sets `inv_o` instead of `mod_o`.
- R9: A write with `wr_en_i` high loads entry `wr_idx_i` at the next clock edge. The fields are taken as follows:
  - mask bits 11:0 from `wr_mask_i`;
  - VPN2 from `wr_hi_i[31:13]`;
  - ASID from `wr_hi_i[7:0]`;
  - from each entry-low image: PFN from [25:6], cacheability from [5:3], dirty from [2], valid from [1] and global from [0].
  
  A lookup issued in the same cycle as a write sees the old contents.
- R10: Reset clears every entry, including both valid bits, and clears all outputs. A lookup that hits a cleared entry reports invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Virtual address to translate |
| lk_asid_i | input | 8 | Current address space identifier |
| lk_store_i | input | 1 | Lookup is for a store |
| wr_en_i | input | 1 | Write one entry |
| wr_idx_i | input | 4 | Entry to write |
| wr_mask_i | input | 12 | Page-size mask image |
| wr_hi_i | input | 32 | Entry-high image (VPN2, ASID) |
| wr_lo0_i | input | 32 | Entry-low image for the even half |
| wr_lo1_i | input | 32 | Entry-low image for the odd half |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| hit_o | output | 1 | An entry matched |
| miss_o | output | 1 | No entry matched |
| idx_o | output | 4 | Matching entry |
| pa_o | output | 32 | Physical address |
| cattr_o | output | 3 | Cacheability code of the selected half |
| dirty_o | output | 1 | Write-enable bit of the selected half |
| pvalid_o | output | 1 | Valid bit of the selected half |
| inv_o | output | 1 | Hit on an invalid half |
| mod_o | output | 1 | Store hit on a valid, non-writable half |

## Verification
The hardest case to reach is a large page whose select bit and passthrough bits are in the middle of the tag field. A wrong mask decode still hits there, but it returns the wrong half or a garbled frame. The bench therefore loads entries of 4 KB, 64 KB, 256 KB, 1 MB and 16 MB. It gives them PFN values with nonzero low bits that must be overwritten, and looks up addresses that differ from the tag only in the bit just above or just at the select position. Write/lookup overlap is reached by driving both ports in the same cycle against an entry that is being replaced.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  localparam int ASID_W   = 8;
  localparam int VPN2_W   = 19;
  localparam int PFN_W    = 20;
  localparam int C_W      = 3;
  localparam int MASK_W   = 12;
  localparam int CM_W     = MASK_W / 2;
  localparam int FIXED_W  = VPN2_W - MASK_W;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic              g;
    logic [CM_W-1:0]   cm;
  } tag_t;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [C_W-1:0]   c;
    logic             d;
    logic             v;
  } half_t;

  function automatic logic [MASK_W-1:0] expand_mask(input logic [CM_W-1:0] cm);
    logic [MASK_W-1:0] m;
    for (int k = 0; k < CM_W; k++) begin
      m[2*k]   = cm[k];
      m[2*k+1] = cm[k];
    end
    return m;
  endfunction

  function automatic logic [CM_W-1:0] compress_mask(input logic [MASK_W-1:0] m);
    logic [CM_W-1:0] cm;
    for (int k = 0; k < CM_W; k++) cm[k] = m[2*k];
    return cm;
  endfunction

  // legal masks are thermometer coded: highest set pair decides
  function automatic logic pick_bit(input logic [CM_W-1:0] cm, input logic [31:0] va);
    logic s;
    s = va[12];
    for (int k = 0; k < CM_W; k++)
      if (cm[k]) s = va[14+2*k];
    return s;
  endfunction

  function automatic logic [31:0] compose_pa(input logic [PFN_W-1:0] pfn,
                                             input logic [CM_W-1:0] cm,
                                             input logic [31:0] va);
    logic [PFN_W-1:0] pm;
    pm = '0;
    for (int k = 0; k < MASK_W; k++) pm[k] = cm[k/2];
    return {(pfn & ~pm) | (va[31:12] & pm), va[11:0]};
  endfunction

  function automatic half_t unpack_lo(input logic [31:0] lo);
    half_t h;
    h.pfn = lo[25:6];
    h.c   = lo[5:3];
    h.d   = lo[2];
    h.v   = lo[1];
    return h;
  endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import pair_tlb_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic [31:0]      wr_hi_i,
  input  logic [31:0]      wr_lo0_i,
  input  logic [31:0]      wr_lo1_i,
  output tag_t             tag_o  [N],
  output half_t            even_o [N],
  output half_t            odd_o  [N]
);
  tag_t  new_tag;
  half_t new_even, new_odd;

  always_comb begin
    new_tag.vpn2 = wr_hi_i[31:13];
    new_tag.asid = wr_hi_i[ASID_W-1:0];
    new_tag.g    = wr_lo0_i[0] & wr_lo1_i[0];
    new_tag.cm   = compress_mask(wr_mask_i);
    new_even     = unpack_lo(wr_lo0_i);
    new_odd      = unpack_lo(wr_lo1_i);
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_o[i]  <= '0;
        even_o[i] <= '0;
        odd_o[i]  <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
        tag_o[i]  <= new_tag;
        even_o[i] <= new_even;
        odd_o[i]  <= new_odd;
      end
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import pair_tlb_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [31:0]       va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  tag_t              tag_i [N],
  output logic [N-1:0]      match_o,
  output logic [N-1:0]      odd_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [VPN2_W-1:0] diff;
    logic [MASK_W-1:0] fm;
    logic              vpn_eq, asid_ok;
    always_comb begin
      fm      = expand_mask(tag_i[i].cm);
      diff    = tag_i[i].vpn2 ^ va_i[31:13];
      vpn_eq  = ~|diff[VPN2_W-1:MASK_W] && ~|(diff[MASK_W-1:0] & ~fm);
      asid_ok = tag_i[i].g || (tag_i[i].asid == asid_i);
    end
    assign match_o[i] = vpn_eq & asid_ok;
    assign odd_o[i]   = pick_bit(tag_i[i].cm, va_i);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
  import pair_tlb_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [31:0]      va_i,
  input  logic [N-1:0]     match_i,
  input  logic [N-1:0]     odd_i,
  input  tag_t             tag_i  [N],
  input  half_t            even_i [N],
  input  half_t            odd_h_i[N],
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [31:0]      pa_o,
  output half_t            half_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (match_i[i]) idx_o = IDX_W'(i);
    hit_o  = |match_i;
    half_o = odd_i[idx_o] ? odd_h_i[idx_o] : even_i[idx_o];
    pa_o   = compose_pa(half_o.pfn, tag_i[idx_o].cm, va_i);
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [31:0]       lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_store_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [MASK_W-1:0] wr_mask_i,
  input  logic [31:0]       wr_hi_i,
  input  logic [31:0]       wr_lo0_i,
  input  logic [31:0]       wr_lo1_i,
  output logic              res_valid_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [31:0]       pa_o,
  output logic [C_W-1:0]    cattr_o,
  output logic              dirty_o,
  output logic              pvalid_o,
  output logic              inv_o,
  output logic              mod_o
);
  tag_t             tags  [N];
  half_t            evens [N];
  half_t            odds  [N];
  logic [N-1:0]     match, odd_sel;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [31:0]      pa;
  half_t            half;
  logic             take;

  tlb_store #(.N(N)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_mask_i, .wr_hi_i, .wr_lo0_i, .wr_lo1_i,
    .tag_o(tags), .even_o(evens), .odd_o(odds)
  );

  tlb_match #(.N(N)) u_match (
    .va_i(lk_va_i), .asid_i(lk_asid_i), .tag_i(tags), .match_o(match), .odd_o(odd_sel)
  );

  tlb_pick #(.N(N)) u_pick (
    .va_i(lk_va_i), .match_i(match), .odd_i(odd_sel), .tag_i(tags),
    .even_i(evens), .odd_h_i(odds), .hit_o(hit), .idx_o(idx), .pa_o(pa), .half_o(half)
  );

  assign take = lk_valid_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      idx_o       <= '0;
      pa_o        <= '0;
      cattr_o     <= '0;
      dirty_o     <= 1'b0;
      pvalid_o    <= 1'b0;
      inv_o       <= 1'b0;
      mod_o       <= 1'b0;
    end else begin
      res_valid_o <= lk_valid_i;
      hit_o       <= take;
      miss_o      <= lk_valid_i & ~hit;
      idx_o       <= take ? idx : '0;
      pa_o        <= take ? pa : '0;
      cattr_o     <= take ? half.c : '0;
      dirty_o     <= take & half.d;
      pvalid_o    <= take & half.v;
      inv_o       <= take & ~half.v;
      mod_o       <= take & half.v & ~half.d & lk_store_i;
    end
  end
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_valid_i,
  input logic [31:0]      lk_va_i,
  input logic             lk_store_i,
  input logic             res_valid_o,
  input logic             hit_o,
  input logic             miss_o,
  input logic [IDX_W-1:0] idx_o,
  input logic [31:0]      pa_o,
  input logic             pvalid_o,
  input logic             dirty_o,
  input logic             inv_o,
  input logic             mod_o
);
  // R1
  result_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (res_valid_o && (hit_o != miss_o)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> (!res_valid_o && !hit_o && !miss_o));
  // R4
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (!hit_o || pa_o[11:0] == $past(lk_va_i[11:0])));
  // R6
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (pa_o == '0 && idx_o == '0 && !inv_o && !mod_o && !pvalid_o));
  // R7
  inv_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> (hit_o && !pvalid_o && !mod_o));
  // R8
  mod_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_o |-> (hit_o && pvalid_o && !dirty_o));
  // R8
  load_no_mod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_store_i) |=> !mod_o);
endmodule

bind pair_tlb pair_tlb_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_va_i(lk_va_i),
  .lk_store_i(lk_store_i), .res_valid_o(res_valid_o), .hit_o(hit_o), .miss_o(miss_o),
  .idx_o(idx_o), .pa_o(pa_o), .pvalid_o(pvalid_o), .dirty_o(dirty_o),
  .inv_o(inv_o), .mod_o(mod_o)
);

// File: tb/sim_pair_tlb.sv
`timescale 1ns/1ps
module sim_pair_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_store = 1'b0, wr_en = 1'b0;
  logic [31:0] lk_va = '0, wr_hi = '0, wr_lo0 = '0, wr_lo1 = '0;
  logic [7:0]  lk_asid = '0;
  logic [3:0]  wr_idx = '0;
  logic [11:0] wr_mask = '0;
  logic        res_valid, hit, miss, dirty, pvalid, inv, mod;
  logic [3:0]  idx;
  logic [31:0] pa;
  logic [2:0]  cattr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pair_tlb u0 (
    .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lk_valid), .lk_va_i(lk_va),
    .lk_asid_i(lk_asid), .lk_store_i(lk_store), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_mask_i(wr_mask), .wr_hi_i(wr_hi), .wr_lo0_i(wr_lo0), .wr_lo1_i(wr_lo1),
    .res_valid_o(res_valid), .hit_o(hit), .miss_o(miss), .idx_o(idx), .pa_o(pa),
    .cattr_o(cattr), .dirty_o(dirty), .pvalid_o(pvalid), .inv_o(inv), .mod_o(mod)
  );

  // va, asid, store | hit, idx, pa, c, d, v, inv, mod
  localparam int NV = 11;
  localparam logic [84:0] VECS [NV] = '{
    {32'h0040_0ABC, 8'h11, 1'b0, 1'b1, 4'd0,  32'h1234_5ABC, 3'd3, 4'b1100},
    {32'h0040_1ABC, 8'h11, 1'b1, 1'b1, 4'd0,  32'h5432_1ABC, 3'd2, 4'b0101},
    {32'h0040_0ABC, 8'h12, 1'b0, 1'b0, 4'd0,  32'h0000_0000, 3'd0, 4'b0000},
    {32'h0A12_3456, 8'h99, 1'b0, 1'b1, 4'd3,  32'h4012_3456, 3'd2, 4'b1100},
    {32'h0B00_0010, 8'h00, 1'b1, 1'b1, 4'd3,  32'h7F00_0010, 3'd3, 4'b1010},
    {32'h1234_5678, 8'h33, 1'b0, 1'b1, 4'd5,  32'h0ABC_5678, 3'd3, 4'b1100},
    {32'h1235_F001, 8'h33, 1'b0, 1'b1, 4'd5,  32'h0DEF_F001, 3'd2, 4'b1100},
    {32'h1236_0000, 8'h33, 1'b0, 1'b0, 4'd0,  32'h0000_0000, 3'd0, 4'b0000},
    {32'hF004_1234, 8'h44, 1'b1, 1'b1, 4'd15, 32'h8F0C_1234, 3'd3, 4'b0101},
    {32'hF000_0000, 8'h44, 1'b0, 1'b1, 4'd15, 32'h8000_0000, 3'd2, 4'b0010},
    {32'h0040_0ABC, 8'h11, 1'b1, 1'b1, 4'd0,  32'h1234_5ABC, 3'd3, 4'b1100}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R3 even 4K";
      1: return "R8 store clean odd";
      2: return "R5 asid mismatch G and";
      3: return "R4 16M global even";
      4: return "R7 16M invalid odd";
      5: return "R4 64K even";
      6: return "R2 64K odd";
      7: return "R6 64K outside";
      8: return "R8 256K store odd";
      9: return "R7 256K invalid even";
      default: return "R8 store dirty ok";
    endcase
  endfunction

  function automatic logic [31:0] mk_lo(logic [19:0] pfn, logic [2:0] c, logic d, logic v, logic g);
    return {6'd0, pfn, c, d, v, g};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] i, logic [11:0] m, logic [31:0] hi, logic [31:0] l0, logic [31:0] l1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_mask = m; wr_hi = hi; wr_lo0 = l0; wr_lo1 = l1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // result packed as hit, miss, idx, pa, c, d, v, inv, mod
  function automatic logic [63:0] got();
    return {19'd0, hit, miss, idx, pa, cattr, dirty, pvalid, inv, mod};
  endfunction

  function automatic logic [63:0] want(logic h, logic [3:0] i, logic [31:0] p, logic [2:0] c, logic [3:0] f);
    return {19'd0, h, ~h, i, p, c, f};
  endfunction

  task automatic look(logic [31:0] va, logic [7:0] asid, logic st);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_store = st;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 outputs cleared in reset
    check("R10 reset outputs", {54'd0, res_valid, got()}, 64'd0);
    rst_n = 1'b1;
    // R10 cleared entries report invalid
    look(32'h0000_0000, 8'h00, 1'b0);
    check("R10 cleared entry invalid", {61'd0, hit, pvalid, inv}, 64'b101);

    wr(4'd0,  12'h000, 32'h0040_0011, mk_lo(20'h12345, 3, 1, 1, 0), mk_lo(20'h54321, 2, 0, 1, 1));
    wr(4'd3,  12'hFFF, 32'h0B00_0022, mk_lo(20'h40000, 2, 1, 1, 1), mk_lo(20'h7F000, 3, 1, 0, 1));
    wr(4'd5,  12'h00F, 32'h1234_0033, mk_lo(20'h0ABCF, 3, 1, 1, 0), mk_lo(20'h0DEF0, 2, 1, 1, 0));
    wr(4'd15, 12'h03F, 32'hF000_0044, mk_lo(20'h80000, 2, 0, 0, 0), mk_lo(20'h8F0FF, 3, 0, 1, 0));

    for (int i = 0; i < NV; i++) begin
      look(VECS[i][84:53], VECS[i][52:45], VECS[i][44]);
      // R1 valid flag follows request
      check({vtag(i), " R1"}, {63'd0, res_valid}, 64'd1);
      check(vtag(i), got(), want(VECS[i][43], VECS[i][42:39], VECS[i][38:7], VECS[i][6:4], VECS[i][3:0]));
    end

    // R1 idle cycle gives no result
    @(negedge clk);
    check("R1 idle", {61'd0, res_valid, hit, miss}, 64'd0);

    // R9 lookup in the write cycle sees old contents
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd5; wr_mask = 12'h000; wr_hi = 32'h2000_0033;
    wr_lo0 = mk_lo(20'h00001, 3, 1, 1, 0); wr_lo1 = mk_lo(20'h00002, 2, 1, 1, 0);
    lk_valid = 1'b1; lk_va = 32'h1234_5678; lk_asid = 8'h33; lk_store = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    check("R9 same-cycle old", got(), want(1, 4'd5, 32'h0ABC_5678, 3'd3, 4'b1100));
    look(32'h1234_5678, 8'h33, 1'b0);
    check("R9 old mapping gone", got(), want(0, 4'd0, 32'd0, 3'd0, 4'b0000));
    look(32'h2000_0FFF, 8'h33, 1'b0);
    check("R9 new mapping", got(), want(1, 4'd5, 32'h0000_1FFF, 3'd3, 4'b1100));

    // R3 R4 1 MB page, select VA[20]
    wr(4'd7, 12'h0FF, 32'h3000_0000, mk_lo(20'hAAAAA, 2, 1, 1, 0), mk_lo(20'hBBBBB, 3, 1, 1, 0));
    look(32'h301F_FFFF, 8'h00, 1'b0);
    check("R3 1M odd", got(), want(1, 4'd7, 32'hBBBF_FFFF, 3'd3, 4'b1100));
    look(32'h300F_FFFF, 8'h00, 1'b0);
    check("R4 1M even", got(), want(1, 4'd7, 32'hAAAF_FFFF, 3'd2, 4'b1100));
    // R2 bit 21 is compared for 1 MB
    look(32'h303F_FFFF, 8'h00, 1'b0);
    check("R2 1M outside", got(), want(0, 4'd0, 32'd0, 3'd0, 4'b0000));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule